// File: doc/BRIEF.md
# Peripheral Interrupt and DMA Request Controller

This block holds the control register and the request logic for a single peripheral channel. A trigger event from the peripheral latches a pending flag. Two mask bits then steer that flag: it becomes a DMA request, a plain interrupt request, or nothing. An end-of-block interrupt pulse marks the end of a DMA block when interrupts are also enabled.

The DMA enable bit clears itself when the external transaction counter reports zero, so a finished block stops requesting. The exception is swap mode, where another buffer takes over and the enable must stay set. A three-bit priority field goes to an external arbiter, where 0 is the most urgent level and 7 the least.

Software reaches the block through an 8-bit write port and a read-back bus. The arbiter and the transfer engine answer on the acknowledge input. Reset is synchronous and active high.

Top module: `pirq_dma_ctrl`

## Requirements
- R1: Read-back layout: bits 7:6 always read 0, bit 5 is the pending flag, bit 4 the DMA enable, bit 3 the end-of-block interrupt enable, bits 2:0 the priority level. A write loads bits 5:0 on the next clock edge.
- R2: A high `trig` sets the pending flag on the next edge. This holds even when a software write of 0 or an `ack` arrives in the same cycle.
- R3: `ack` with no trigger and no write clears the pending flag on the next edge.
- R4: A software write sets or clears the pending flag from bit 5, and this wins over a concurrent `ack`.
- R5: `cnt_zero` high with `swap_mode` low clears the DMA enable on the next edge, overriding a concurrent write. With `swap_mode` high the enable is left as it was.
- R6: `dma_req` is high in the same cycle that pending and DMA enable are both 1.
- R7: `irq_req` is high in the same cycle that pending is 1, DMA enable is 0 and interrupt enable is 1. It is never high together with `dma_req`.
- R8: `eob_irq` is a single-cycle pulse. It appears one edge after a cycle in which `cnt_zero` rises (low in the previous cycle, or first cycle after reset) while both enables are 1.
- R9: `prio` always equals the stored priority field (0 highest, 7 lowest).
- R10: Synchronous reset clears every register bit and the pulse output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr_en | input | 1 | Software register write strobe |
| reg_wdata | input | 8 | Software write data |
| reg_rdata | output | 8 | Register read-back |
| trig | input | 1 | Peripheral trigger event |
| ack | input | 1 | Request acknowledge |
| cnt_zero | input | 1 | Transaction counter has reached zero |
| swap_mode | input | 1 | Double-buffer swap mode active |
| dma_req | output | 1 | DMA request to the arbiter |
| irq_req | output | 1 | Interrupt request (no DMA) |
| eob_irq | output | 1 | End-of-block interrupt pulse |
| prio | output | 3 | Priority level, 0 highest |

## Verification
The register contents respond one edge after a write, trigger, acknowledge or counter-zero input. `dma_req`, `irq_req` and `prio` follow the registers in the same cycle. `eob_irq` is registered, so it shows one edge after the counter-zero rise. The bench drives inputs on the falling edge and updates a behavioural model on the rising edge. It compares every output on the next falling edge, which places each check in the cycle where the result is due. Directed cases cover trigger-versus-clear collisions, counter-zero with and without swap mode, and all four mask combinations. Random traffic follows the directed cases.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int unsigned BIT_PEND = 5;
  localparam int unsigned BIT_DMEN = 4;
  localparam int unsigned BIT_IEN  = 3;

  // Steer the pending flag: {dma, irq}
  function automatic logic [1:0] steer_req(input logic pend, input logic dmen, input logic ien);
    logic [1:0] r;
    r[1] = pend & dmen;
    r[0] = pend & ~dmen & ien;
    return r;
  endfunction

  // Next value of the pending flag; trigger outranks write, write outranks ack
  function automatic logic next_pend(input logic cur, input logic trg, input logic wr,
                                     input logic wval, input logic ak);
    if (trg)      return 1'b1;
    else if (wr)  return wval;
    else if (ak)  return 1'b0;
    else          return cur;
  endfunction
endpackage

// File: rtl/pirq_pend_flag.sv
module pirq_pend_flag (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  input  logic wr_en,
  input  logic wr_val,
  input  logic ack,
  output logic pend
);
  import pirq_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= next_pend(pend, trig, wr_en, wr_val, ack);
  end
endmodule

// File: rtl/pirq_mask_bank.sv
module pirq_mask_bank #(
  parameter int unsigned PRIO_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_dmen,
  input  logic              wr_ien,
  input  logic [PRIO_W-1:0] wr_prio,
  input  logic              cnt_zero,
  input  logic              swap_mode,
  output logic              dmen,
  output logic              ien,
  output logic [PRIO_W-1:0] prio_lvl,
  output logic              dm_autoclr
);
  assign dm_autoclr = cnt_zero & ~swap_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      dmen     <= 1'b0;
      ien      <= 1'b0;
      prio_lvl <= '0;
    end else begin
      if (dm_autoclr)  dmen <= 1'b0;
      else if (wr_en)  dmen <= wr_dmen;
      if (wr_en) begin
        ien      <= wr_ien;
        prio_lvl <= wr_prio;
      end
    end
  end
endmodule

// File: rtl/pirq_eob_pulse.sv
module pirq_eob_pulse (
  input  logic clk,
  input  logic rst,
  input  logic cnt_zero,
  input  logic armed,
  output logic eob
);
  logic cz_q;
  logic cz_rise;

  assign cz_rise = cnt_zero & ~cz_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cz_q <= 1'b0;
      eob  <= 1'b0;
    end else begin
      cz_q <= cnt_zero;
      eob  <= cz_rise & armed;
    end
  end
endmodule

// File: rtl/pirq_dma_ctrl.sv
module pirq_dma_ctrl #(
  parameter int unsigned REG_W  = 8,
  parameter int unsigned PRIO_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              trig,
  input  logic              ack,
  input  logic              cnt_zero,
  input  logic              swap_mode,
  output logic              dma_req,
  output logic              irq_req,
  output logic              eob_irq,
  output logic [PRIO_W-1:0] prio
);
  import pirq_pkg::*;

  localparam int unsigned USED_W = BIT_PEND + 1;

  logic              pend;
  logic              dmen;
  logic              ien;
  logic [PRIO_W-1:0] prio_lvl;
  logic              dm_autoclr;
  logic              eob_armed;
  logic [1:0]        req_vec;

  pirq_pend_flag u_pend (
    .clk    (clk),
    .rst    (rst),
    .trig   (trig),
    .wr_en  (reg_wr_en),
    .wr_val (reg_wdata[BIT_PEND]),
    .ack    (ack),
    .pend   (pend)
  );

  pirq_mask_bank #(.PRIO_W(PRIO_W)) u_mask (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (reg_wr_en),
    .wr_dmen    (reg_wdata[BIT_DMEN]),
    .wr_ien     (reg_wdata[BIT_IEN]),
    .wr_prio    (reg_wdata[PRIO_W-1:0]),
    .cnt_zero   (cnt_zero),
    .swap_mode  (swap_mode),
    .dmen       (dmen),
    .ien        (ien),
    .prio_lvl   (prio_lvl),
    .dm_autoclr (dm_autoclr)
  );

  assign eob_armed = dmen & ien;

  pirq_eob_pulse u_eob (
    .clk      (clk),
    .rst      (rst),
    .cnt_zero (cnt_zero),
    .armed    (eob_armed),
    .eob      (eob_irq)
  );

  assign req_vec = steer_req(pend, dmen, ien);
  assign dma_req = req_vec[1];
  assign irq_req = req_vec[0];
  assign prio    = prio_lvl;

  always_comb begin
    reg_rdata                = '0;
    reg_rdata[BIT_PEND]      = pend;
    reg_rdata[BIT_DMEN]      = dmen;
    reg_rdata[BIT_IEN]       = ien;
    reg_rdata[PRIO_W-1:0]    = prio_lvl;
  end

  if (USED_W > REG_W) begin : g_bad_width
    initial $error("register too narrow");
  end
endmodule

// File: rtl/pirq_dma_ctrl_chk.sv
module pirq_dma_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_wr_en,
  input logic [7:0] reg_rdata,
  input logic       trig,
  input logic       ack,
  input logic       cnt_zero,
  input logic       swap_mode,
  input logic       dma_req,
  input logic       irq_req,
  input logic       eob_irq,
  input logic [2:0] prio,
  input logic       dm_autoclr
);
  AST_TOP_BITS_ZERO: assert property (@(posedge clk) disable iff (rst) reg_rdata[7:6] == 2'b00); // R1
  AST_TRIG_SETS_PEND: assert property (@(posedge clk) disable iff (rst) trig |=> reg_rdata[5]); // R2
  AST_ACK_CLEARS_PEND: assert property (@(posedge clk) disable iff (rst) (ack && !trig && !reg_wr_en) |=> !reg_rdata[5]); // R3
  AST_DMEN_AUTOCLR: assert property (@(posedge clk) disable iff (rst) dm_autoclr |=> !reg_rdata[4]); // R5
  AST_SWAP_KEEPS_DMEN: assert property (@(posedge clk) disable iff (rst) (cnt_zero && swap_mode && reg_rdata[4] && !reg_wr_en) |=> reg_rdata[4]); // R5
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(dma_req && irq_req)); // R7
  AST_DMA_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst) dma_req |-> (reg_rdata[5] && reg_rdata[4])); // R6
  AST_EOB_SINGLE: assert property (@(posedge clk) disable iff (rst) eob_irq |=> !eob_irq); // R8
  AST_PRIO_MATCH: assert property (@(posedge clk) disable iff (rst) prio == reg_rdata[2:0]); // R9
endmodule

bind pirq_dma_ctrl pirq_dma_ctrl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_wr_en  (reg_wr_en),
  .reg_rdata  (reg_rdata),
  .trig       (trig),
  .ack        (ack),
  .cnt_zero   (cnt_zero),
  .swap_mode  (swap_mode),
  .dma_req    (dma_req),
  .irq_req    (irq_req),
  .eob_irq    (eob_irq),
  .prio       (prio),
  .dm_autoclr (dm_autoclr)
);

// File: tb/pirq_dma_ctrl_bench.sv
module pirq_dma_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       trig = 1'b0;
  logic       ack = 1'b0;
  logic       cnt_zero = 1'b0;
  logic       swap_mode = 1'b0;
  logic       dma_req;
  logic       irq_req;
  logic       eob_irq;
  logic [2:0] prio;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  // behavioural model state
  bit m_pend, m_dm, m_im, m_czd, m_eob;
  int m_prl;

  always #2 clk = ~clk;

  pirq_dma_ctrl u_pirq_dma_ctrl (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .trig(trig), .ack(ack), .cnt_zero(cnt_zero),
    .swap_mode(swap_mode), .dma_req(dma_req), .irq_req(irq_req),
    .eob_irq(eob_irq), .prio(prio)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      m_pend = 0; m_dm = 0; m_im = 0; m_prl = 0; m_czd = 0; m_eob = 0;
    end else begin
      m_eob = cnt_zero && !m_czd && m_dm && m_im;
      m_czd = cnt_zero;
      if (trig)           m_pend = 1;
      else if (reg_wr_en) m_pend = reg_wdata[5];
      else if (ack)       m_pend = 0;
      if (cnt_zero && !swap_mode) m_dm = 0;
      else if (reg_wr_en)         m_dm = reg_wdata[4];
      if (reg_wr_en) begin
        m_im  = reg_wdata[3];
        m_prl = reg_wdata[2:0];
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  int exp_rd;
  always @(negedge clk) begin
    if (!rst && !done) begin
      exp_rd = (int'(m_pend) << 5) | (int'(m_dm) << 4) | (int'(m_im) << 3) | m_prl;
      check("R1 register read-back", reg_rdata, exp_rd);
      check("R2,R3,R4 pending flag", reg_rdata[5], m_pend);
      check("R5 DMA enable", reg_rdata[4], m_dm);
      check("R6 dma_req", dma_req, m_pend && m_dm);
      check("R7 irq_req", irq_req, m_pend && !m_dm && m_im);
      check("R8 eob_irq", eob_irq, m_eob);
      check("R9 prio", prio, m_prl);
    end
  end

  task automatic step(input bit w, input logic [7:0] d, input bit t, input bit a,
                      input bit cz, input bit sw);
    reg_wr_en = w; reg_wdata = d; trig = t; ack = a; cnt_zero = cz; swap_mode = sw;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    // R10: reset state, with a write pending during reset
    reg_wr_en = 1; reg_wdata = 8'h3F; trig = 1;
    @(negedge clk);
    check("R10 reset read-back", reg_rdata, 0);
    check("R10 reset eob", eob_irq, 0);
    reg_wr_en = 0; trig = 0;
    rst = 0;
    @(negedge clk);

    // R1/R9: write all fields, bits 7:6 must read zero
    step(1, 8'hDD, 0, 0, 0, 0);      // pend=0 dm=1 im=1 prio=5
    check("R1 top bits zero", reg_rdata[7:6], 0);
    check("R9 prio=5", prio, 5);
    // R6/R8: both masks set, trigger -> DMA request
    step(0, 8'h00, 1, 0, 0, 0);
    check("R6 dma_req after trigger", dma_req, 1);
    // R3: acknowledge clears
    step(0, 8'h00, 0, 1, 0, 0);
    check("R3 ack clears", reg_rdata[5], 0);
    // R2: trigger beats software clear and ack
    step(1, 8'h18, 1, 1, 0, 0);
    check("R2 trigger wins", reg_rdata[5], 1);
    // R8/R5: counter zero, no swap -> dm cleared, eob pulse
    step(0, 8'h00, 0, 0, 1, 0);
    check("R5 dm auto-cleared", reg_rdata[4], 0);
    check("R8 eob pulse", eob_irq, 1);
    step(0, 8'h00, 0, 0, 1, 0);
    check("R8 eob single cycle", eob_irq, 0);
    check("R7 irq_req with dm=0 im=1", irq_req, 1);
    // R5: swap mode keeps dm
    step(1, 8'h10, 0, 0, 0, 0);
    step(0, 8'h00, 0, 0, 1, 1);
    check("R5 swap keeps dm", reg_rdata[4], 1);
    // R5: clear beats concurrent write
    step(1, 8'h10, 0, 0, 1, 0);
    check("R5 clear beats write", reg_rdata[4], 0);
    // R4: software set, then software write beats ack
    step(1, 8'h20, 0, 0, 0, 0);
    check("R4 sw set pending", reg_rdata[5], 1);
    check("R7 nothing with both masks 0", dma_req | irq_req, 0);
    step(1, 8'h20, 0, 1, 0, 0);
    check("R4 write beats ack", reg_rdata[5], 1);
    step(1, 8'h00, 0, 0, 0, 0);
    check("R4 sw cancel", reg_rdata[5], 0);
    idle(2);

    // random traffic, compared every cycle
    for (int i = 0; i < 3000; i++) begin
      automatic int r = $urandom;
      step(r[2:0] == 0, 8'($urandom), r[5:3] == 0, r[8:6] == 0,
           r[10:9] == 0, r[11]);
      if (r[15:12] == 0) begin
        rst = 1; @(negedge clk); rst = 0;
      end
    end
    idle(2);
    finish_run();
  end

  initial begin
    #100000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end
endmodule